// File: doc/BRIEF.md
# DRAM Controller Operating-Mode Sequencer

This block holds the top-level operating mode of a DRAM controller. Software posts a mode-change request as a small command code. It reads the current mode back from a status word. The modes are memory initialisation, configuration, normal access and low power. Every move between modes that needs the memory side to act passes through a visible request mode. The sequencer stays in that request mode until the memory side returns the matching acknowledge.

Three acknowledges come from the memory side. A quiesce acknowledge completes a move into configuration or into access. A self-refresh-entered acknowledge completes a move into low power. A self-refresh-exited acknowledge completes the wake from low power. The block issues no DRAM commands and counts no timing; it only sequences the modes and reports the current one.

Top module: `memctl_mode_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the mode becomes init-memory (code 0), and the whole status word reads zero after that edge.
- R2: The mode code sits in status bits [2:0], with 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request and 7 low-power-exit-request. Every status bit above bit 2 always reads zero.
- R3: A request is the value of `req_code` in a cycle where `req_valid` is high. The codes are 1 config, 2 go, 3 sleep and 4 wakeup. Code 0 (init) and codes 5 to 7 never change the mode.
- R4: A config request taken in init-memory or in access gives config-request after the edge. The mode then becomes config at the first later edge where `quiesce_ack` is high.
- R5: A go request taken in config gives access-request after the edge. The mode then becomes access at the first later edge where `quiesce_ack` is high.
- R6: A sleep request taken in access gives low-power-entry-request after the edge. That mode holds for as many cycles as `sr_entry_ack` stays low, and it becomes low-power at the first edge where `sr_entry_ack` is high.
- R7: A wakeup request taken in low-power gives low-power-exit-request after the edge. The mode then becomes access, never config, at the first later edge where `sr_exit_ack` is high.
- R8: A request code that R4 to R7 do not accept in the current mode leaves the mode unchanged. This includes any request made in one of the four request modes.
- R9: An acknowledge acts only while the mode is the request mode it completes. An acknowledge seen in a stable mode is ignored, and so is one that arrives in the same cycle as the request it would complete. The request mode is therefore shown for at least one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Qualifies `req_code` for this cycle |
| req_code | input | 3 | Mode-change command code |
| quiesce_ack | input | 1 | Memory side is quiet; completes a config or go move |
| sr_entry_ack | input | 1 | Memory has entered self-refresh |
| sr_exit_ack | input | 1 | Memory has left self-refresh |
| status_o | output | STAT_W (32) | Status word; mode code in bits [2:0] |

## Verification
A new request and an acknowledge from the memory side can arrive in the same cycle. Two cases matter. In the first, an acknowledge comes in the cycle a request is accepted, for example sleep in access together with `sr_entry_ack`. In the second, a new request comes while a request mode is being completed, for example go together with `quiesce_ack` while in config-request. The bench reaches each of the eight modes along a legal path. In that mode it applies every request code, with and without `req_valid`, combined with each of the eight acknowledge patterns. It then compares the mode after the edge against a transition function built from the requirements. An accepted request must land in its request mode and not jump past it. A completion must land in its stable mode no matter what request comes with it.

// File: rtl/memctl_mode_pkg.sv
package memctl_mode_pkg;

    localparam int MODE_W = 3;
    localparam int CODE_W = 3;

    // Mode codes as reported in status bits [2:0]
    typedef enum logic [MODE_W-1:0] {
        MD_INIT    = 3'd0,
        MD_CFG     = 3'd1,
        MD_CFG_REQ = 3'd2,
        MD_ACC     = 3'd3,
        MD_ACC_REQ = 3'd4,
        MD_LP      = 3'd5,
        MD_LP_ENT  = 3'd6,
        MD_LP_EXIT = 3'd7
    } mode_e;

    // Request command codes
    typedef enum logic [CODE_W-1:0] {
        CMD_INIT  = 3'd0,
        CMD_CFG   = 3'd1,
        CMD_GO    = 3'd2,
        CMD_SLEEP = 3'd3,
        CMD_WAKE  = 3'd4
    } cmd_e;

    // Decoded request, at most one bit set
    typedef struct packed {
        logic cfg;
        logic go;
        logic sleep;
        logic wake;
    } req_t;

    // Acknowledges from the memory side
    typedef struct packed {
        logic quiesce;
        logic sr_in;
        logic sr_out;
    } ack_t;

    function automatic logic mode_is_transient(mode_e m);
        return (m == MD_CFG_REQ) || (m == MD_ACC_REQ) ||
               (m == MD_LP_ENT)  || (m == MD_LP_EXIT);
    endfunction

endpackage

// File: rtl/memctl_req_decode.sv
module memctl_req_decode
    import memctl_mode_pkg::*;
(
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    output req_t              req
);
    always_comb begin
        req = '0;
        if (req_valid) begin
            case (req_code)
                CMD_CFG:   req.cfg   = 1'b1;
                CMD_GO:    req.go    = 1'b1;
                CMD_SLEEP: req.sleep = 1'b1;
                CMD_WAKE:  req.wake  = 1'b1;
                default:   req       = '0; // init and undefined codes
            endcase
        end
    end
endmodule

// File: rtl/memctl_mode_next.sv
module memctl_mode_next
    import memctl_mode_pkg::*;
(
    input  mode_e cur,
    input  req_t  req,
    input  ack_t  ack,
    output mode_e nxt
);
    always_comb begin
        nxt = cur;
        unique case (cur)
            MD_INIT:    if (req.cfg)     nxt = MD_CFG_REQ;
            MD_CFG:     if (req.go)      nxt = MD_ACC_REQ;
            MD_ACC: begin
                if (req.cfg)             nxt = MD_CFG_REQ;
                else if (req.sleep)      nxt = MD_LP_ENT;
            end
            MD_LP:      if (req.wake)    nxt = MD_LP_EXIT;
            MD_CFG_REQ: if (ack.quiesce) nxt = MD_CFG;
            MD_ACC_REQ: if (ack.quiesce) nxt = MD_ACC;
            MD_LP_ENT:  if (ack.sr_in)   nxt = MD_LP;
            MD_LP_EXIT: if (ack.sr_out)  nxt = MD_ACC;
            default:                     nxt = cur;
        endcase
    end
endmodule

// File: rtl/memctl_status_fmt.sv
module memctl_status_fmt
    import memctl_mode_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  mode_e             mode,
    output logic [STAT_W-1:0] status
);
    localparam int PAD_W = STAT_W - MODE_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign status = {{PAD_W{1'b0}}, mode};
        end else begin : g_nopad
            assign status = mode;
        end
    endgenerate
endmodule

// File: rtl/memctl_mode_fsm.sv
module memctl_mode_fsm
    import memctl_mode_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic              quiesce_ack,
    input  logic              sr_entry_ack,
    input  logic              sr_exit_ack,
    output logic [STAT_W-1:0] status_o
);
    mode_e mode_q;
    mode_e mode_d;
    req_t  req;
    ack_t  ack;

    assign ack = '{quiesce: quiesce_ack, sr_in: sr_entry_ack, sr_out: sr_exit_ack};

    memctl_req_decode u_dec (
        .req_valid (req_valid),
        .req_code  (req_code),
        .req       (req)
    );

    memctl_mode_next u_next (
        .cur (mode_q),
        .req (req),
        .ack (ack),
        .nxt (mode_d)
    );

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MD_INIT;
        else     mode_q <= mode_d;
    end

    memctl_status_fmt #(.STAT_W(STAT_W)) u_fmt (
        .mode   (mode_q),
        .status (status_o)
    );
endmodule

// File: rtl/memctl_mode_chk.sv
module memctl_mode_chk
    import memctl_mode_pkg::*;
#(
    parameter int STAT_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [CODE_W-1:0] req_code,
    input logic              quiesce_ack,
    input logic              sr_entry_ack,
    input logic              sr_exit_ack,
    input logic [STAT_W-1:0] status_o
);
    logic [MODE_W-1:0] md;
    assign md = status_o[MODE_W-1:0];

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (status_o >> MODE_W) == '0);

    // R4
    cfg_enter_chk: assert property (@(posedge clk) disable iff (rst)
        ((md == MD_INIT) || (md == MD_ACC)) && req_valid && req_code == CMD_CFG
        |=> md == MD_CFG_REQ);

    // R4
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_CFG_REQ) && !quiesce_ack |=> md == MD_CFG_REQ);

    // R5
    go_done_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_ACC_REQ) && quiesce_ack |=> md == MD_ACC);

    // R6
    lp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_LP_ENT) && !sr_entry_ack |=> md == MD_LP_ENT);

    // R6
    lp_done_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_LP_ENT) && sr_entry_ack |=> md == MD_LP);

    // R7
    wake_done_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_LP_EXIT) && sr_exit_ack |=> md == MD_ACC);

    // R9
    stable_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mode_is_transient(mode_e'(md)) && !req_valid |=> $stable(md));

    // R8
    transient_req_chk: assert property (@(posedge clk) disable iff (rst)
        (md == MD_LP_EXIT) && !sr_exit_ack && req_valid |=> md == MD_LP_EXIT);
endmodule

bind memctl_mode_fsm memctl_mode_chk #(.STAT_W(STAT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_code     (req_code),
    .quiesce_ack  (quiesce_ack),
    .sr_entry_ack (sr_entry_ack),
    .sr_exit_ack  (sr_exit_ack),
    .status_o     (status_o)
);

// File: tb/tb_memctl_mode_fsm.sv
`timescale 1ns/1ps
module tb_memctl_mode_fsm;
    localparam int STAT_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_code = 3'd0;
    logic              quiesce_ack = 1'b0;
    logic              sr_entry_ack = 1'b0;
    logic              sr_exit_ack = 1'b0;
    logic [STAT_W-1:0] status_o;

    int n_run  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    memctl_mode_fsm #(.STAT_W(STAT_W)) dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_code     (req_code),
        .quiesce_ack  (quiesce_ack),
        .sr_entry_ack (sr_entry_ack),
        .sr_exit_ack  (sr_exit_ack),
        .status_o     (status_o)
    );

    // Expected mode after one edge, from R3..R9
    function automatic int exp_next(int st, bit v, int c, bit qa, bit ea, bit xa);
        case (st)
            0: return (v && c == 1) ? 2 : 0;
            1: return (v && c == 2) ? 4 : 1;
            2: return qa ? 1 : 2;
            3: return (v && c == 1) ? 2 : ((v && c == 3) ? 6 : 3);
            4: return qa ? 3 : 4;
            5: return (v && c == 4) ? 7 : 5;
            6: return ea ? 5 : 6;
            default: return xa ? 3 : 7;
        endcase
    endfunction

    function automatic string tag_of(int st, bit v, int c, bit qa, bit ea, bit xa);
        bit trans = (st == 2) || (st == 4) || (st == 6) || (st == 7);
        if (trans) return (qa || ea || xa) ? "R9" : "R8";
        if (!v) return "R9";
        if (c == 0 || c > 4) return "R3";
        if (c == 1 && (st == 0 || st == 3)) return "R4";
        if (c == 2 && st == 1) return "R5";
        if (c == 3 && st == 3) return "R6";
        if (c == 4 && st == 5) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic [STAT_W-1:0] act, logic [STAT_W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: status actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic step(bit v, int c, bit qa, bit ea, bit xa);
        req_valid    = v;
        req_code     = 3'(c);
        quiesce_ack  = qa;
        sr_entry_ack = ea;
        sr_exit_ack  = xa;
        @(posedge clk);
        #1;
        req_valid    = 1'b0;
        req_code     = 3'd0;
        quiesce_ack  = 1'b0;
        sr_entry_ack = 1'b0;
        sr_exit_ack  = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    // Legal path index: 0 INIT,1 CFG_REQ,2 CFG,3 ACC_REQ,4 ACC,5 LP_ENT,6 LP,7 LP_EXIT
    task automatic path_step(int k);
        case (k)
            0: step(1, 1, 0, 0, 0);
            1: step(0, 0, 1, 0, 0);
            2: step(1, 2, 0, 0, 0);
            3: step(0, 0, 1, 0, 0);
            4: step(1, 3, 0, 0, 0);
            5: step(0, 0, 0, 1, 0);
            default: step(1, 4, 0, 0, 0);
        endcase
    endtask

    function automatic int path_idx(int st);
        case (st)
            0: return 0;
            2: return 1;
            1: return 2;
            4: return 3;
            3: return 4;
            6: return 5;
            5: return 6;
            default: return 7;
        endcase
    endfunction

    task automatic goto_mode(int st);
        do_reset();
        for (int k = 0; k < path_idx(st); k++) path_step(k);
    endtask

    initial begin
        #(4 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // R1: reset state
        check("R1", status_o, '0);

        // R2: each mode along the path shows its code with upper bits zero
        for (int st = 0; st < 8; st++) begin
            goto_mode(st);
            check("R2", status_o, STAT_W'(st));
        end

        // Near-exhaustive sweep: every mode x code/valid x ack pattern
        for (int st = 0; st < 8; st++) begin
            for (int vc = 0; vc < 9; vc++) begin
                for (int a = 0; a < 8; a++) begin
                    bit v  = (vc < 8);
                    int c  = v ? vc : 0;
                    bit qa = a[0];
                    bit ea = a[1];
                    bit xa = a[2];
                    goto_mode(st);
                    step(v, c, qa, ea, xa);
                    check(tag_of(st, v, c, qa, ea, xa), status_o,
                          STAT_W'(exp_next(st, v, c, qa, ea, xa)));
                end
            end
        end

        // R6: entry request held over several cycles without acknowledge
        goto_mode(6);
        for (int k = 0; k < 5; k++) step(0, 0, 1, 0, 1);
        check("R6", status_o, STAT_W'(6));
        step(0, 0, 0, 1, 0);
        check("R6", status_o, STAT_W'(5));

        // R7: wake returns to access; a following config is a separate move
        step(1, 4, 0, 0, 0);
        check("R7", status_o, STAT_W'(7));
        step(0, 0, 0, 0, 1);
        check("R7", status_o, STAT_W'(3));
        step(1, 1, 0, 0, 0);
        check("R4", status_o, STAT_W'(2));
        step(0, 0, 1, 0, 0);
        check("R4", status_o, STAT_W'(1));

        // R3: init code has no effect in config
        step(1, 0, 0, 0, 0);
        check("R3", status_o, STAT_W'(1));

        // R1: reset from a deep mode
        goto_mode(7);
        do_reset();
        check("R1", status_o, '0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule